// File: doc/BRIEF.md
# Toggle-Encoded Lookup Table Decoder

This block returns one full word of a constant lookup table when given a row number. To save storage, most table columns are not held bit by bit. Each such column keeps only an ascending list of the rows at which its bit differs from the row above it. A few columns that would not shrink this way are kept in an ordinary word-per-row store and read directly at the requested row.

To rebuild a compressed column bit, the block walks that column's toggle list one entry per clock. It counts how many listed rows are at or below the requested row. An odd count gives 1 and an even count gives 0. All compressed columns walk their lists in parallel. The word is released with a one-cycle valid pulse once every column has stopped. A busy flag covers the whole walk. The table contents and toggle lists come from an offline build step and are fixed as the initial contents of the memories.

Top module: `toggle_lut_decoder`

## Requirements
- R1: After reset, `wordVld` and `busy` are 0 and `wordOut` is all zeros.
- R2: For each compressed column (a 1 in `COMP_MASK` at the column's bit position), the output bit equals the parity of the number of toggle rows less than or equal to the requested row. A toggle row is a row r ≥ 1 whose bit differs from row r−1, and row 0 of every compressed column is 0.
- R3: For each plain column (a 0 in `COMP_MASK`), the output bit equals the stored bit at the requested row.
- R4: A compressed column whose toggle list is empty (column `WORD_W-2` in the default table) decodes to 0 for every row.
- R5: A compressed column whose only toggle lies on the last row (column `WORD_W-1` in the default table) decodes to 1 for the last row and to 0 for every other row.
- R6: A request is taken when `reqVld` is high and `busy` is low. From the next cycle `busy` is high until the result is out. `wordVld` is a single-cycle pulse, and `busy` is low in that cycle.
- R7: A `reqVld` pulse that arrives while `busy` is high is dropped. The pending result still belongs to the first row, and the dropped request produces no later `wordVld`.
- R8: The number of clock edges from the accepting edge to the edge that raises `wordVld` is S+1. S is the largest count of toggle rows at or below the requested row over all compressed columns. S never exceeds `NUM_ROWS`.
- R9: For every row index, the decoded word equals the full table word of that row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqVld | input | 1 | Request strobe, taken when not busy |
| reqIdx | input | IDX_W ($clog2(NUM_ROWS)) | Row number to decode |
| busy | output | 1 | High while a toggle-list walk is in progress |
| wordVld | output | 1 | One-cycle pulse marking a fresh `wordOut` |
| wordOut | output | WORD_W | Decoded table word, held until the next result |

## Verification
The assertions assume that the requested row is below `NUM_ROWS`. They also assume that every stored toggle list is strictly ascending and no longer than the row count. Given that, the walk pointer never passes a column's list length and a walk ends within a bounded number of cycles.

The stimulus draws row numbers only from the valid range. It uses the built-in table, whose lists hold these properties. Its only request made while busy is the deliberate one in the drop test.

// File: rtl/tdec_pkg.sv
package tdec_pkg;

  typedef struct packed {
    logic start;   // accept a request, latch the row, clear the walk
    logic search;  // a walk is in progress
    logic finish;  // capture the assembled word
  } tdecStrb_t;

  // Built-in table content: the result of the offline build step.
  function automatic logic cellBit(int row, int col, int rows, int width, int idxW);
    int g;
    g = row ^ (row >> 1);
    if (col == width - 1) return (row == rows - 1);
    if (col == width - 2) return 1'b0;
    if (col % 2 == 0) return 1'(g >> ((col / 2) % idxW));
    return 1'((row * 5 + 3) >> ((col / 2) % idxW));
  endfunction

  function automatic int toggleCount(int col, int rows, int width, int idxW);
    int n;
    n = 0;
    for (int r = 1; r < rows; r++)
      if (cellBit(r, col, rows, width, idxW) != cellBit(r - 1, col, rows, width, idxW)) n++;
    return n;
  endfunction

  // Row of the k-th toggle of a column, or -1 past the end of the list.
  function automatic int toggleRow(int col, int k, int rows, int width, int idxW);
    int n;
    n = 0;
    for (int r = 1; r < rows; r++)
      if (cellBit(r, col, rows, width, idxW) != cellBit(r - 1, col, rows, width, idxW)) begin
        if (n == k) return r;
        n++;
      end
    return -1;
  endfunction

endpackage

// File: rtl/tdec_ctrl.sv
module tdec_ctrl
  import tdec_pkg::*;
#(
  parameter int NUM_ROWS = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqVld,
  input  logic      allDone,
  output tdecStrb_t strb,
  output logic      busy,
  output logic      wordVld
);
  localparam int CNT_W = $clog2(NUM_ROWS + 2) + 1;

  typedef enum logic {ST_IDLE, ST_WALK} state_t;
  state_t state;

  always_comb begin
    strb.start  = (state == ST_IDLE) && reqVld;
    strb.search = (state == ST_WALK);
    strb.finish = (state == ST_WALK) && allDone;
  end

  assign busy = (state == ST_WALK);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      wordVld <= 1'b0;
    end else begin
      wordVld <= strb.finish;
      if (strb.start) state <= ST_WALK;
      else if (strb.finish) state <= ST_IDLE;
    end
  end

  // Cycle count of the current walk, for the latency bound check.
  logic [CNT_W-1:0] walkCnt;
  always_ff @(posedge clk) begin
    if (!rstN || !busy) walkCnt <= '0;
    else walkCnt <= walkCnt + 1'b1;
  end

  assert_latency_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    int'(walkCnt) <= NUM_ROWS);

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    wordVld |=> !wordVld);

  assert_result_follows_walk_R6: assert property (@(posedge clk) disable iff (!rstN)
    wordVld |-> $past(busy) && !busy);

endmodule

// File: rtl/tdec_dpath.sv
module tdec_dpath
  import tdec_pkg::*;
#(
  parameter int              NUM_ROWS  = 16,
  parameter int              WORD_W    = 8,
  parameter logic [WORD_W-1:0] COMP_MASK = 8'hD5,
  localparam int             IDX_W     = $clog2(NUM_ROWS),
  localparam int             PTR_W     = $clog2(NUM_ROWS) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  tdecStrb_t         strb,
  input  logic [IDX_W-1:0]  reqIdx,
  output logic              allDone,
  output logic [WORD_W-1:0] wordOut
);
  localparam int TDEPTH = 2 ** PTR_W;

  logic [IDX_W-1:0]  idxQ;
  logic [WORD_W-1:0] colDone;
  logic [WORD_W-1:0] wordNext;

  // Plain store: only the uncompressed columns carry content.
  logic [WORD_W-1:0] plainMem [NUM_ROWS];
  initial begin
    for (int r = 0; r < NUM_ROWS; r++)
      for (int c = 0; c < WORD_W; c++)
        plainMem[r][c] = COMP_MASK[c] ? 1'b0 : cellBit(r, c, NUM_ROWS, WORD_W, IDX_W);
  end

  always_ff @(posedge clk) begin
    if (!rstN) idxQ <= '0;
    else if (strb.start) idxQ <= reqIdx;
  end

  for (genvar c = 0; c < WORD_W; c++) begin : g_col
    if (COMP_MASK[c]) begin : g_comp
      localparam int LEN = toggleCount(c, NUM_ROWS, WORD_W, IDX_W);
      logic [IDX_W-1:0] togMem [TDEPTH];
      logic [PTR_W-1:0] ptr;
      logic             hit;

      initial begin
        int tr;
        for (int k = 0; k < TDEPTH; k++) begin
          tr = toggleRow(c, k, NUM_ROWS, WORD_W, IDX_W);
          togMem[k] = (tr < 0) ? '1 : IDX_W'(tr);
        end
      end

      assign hit = (int'(ptr) < LEN) && (togMem[ptr] <= idxQ);

      always_ff @(posedge clk) begin
        if (!rstN) ptr <= '0;
        else if (strb.start) ptr <= '0;
        else if (strb.search && hit) ptr <= ptr + 1'b1;
      end

      assign colDone[c]  = !hit;
      assign wordNext[c] = ptr[0];

      assert_ptr_in_list_R2: assert property (@(posedge clk) disable iff (!rstN)
        int'(ptr) <= LEN);
    end else begin : g_plain
      assign colDone[c]  = 1'b1;
      assign wordNext[c] = plainMem[idxQ][c];
    end
  end

  assign allDone = &colDone;

  always_ff @(posedge clk) begin
    if (!rstN) wordOut <= '0;
    else if (strb.finish) wordOut <= wordNext;
  end

  assert_row_held_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.search |=> $stable(idxQ));

endmodule

// File: rtl/toggle_lut_decoder.sv
module toggle_lut_decoder
  import tdec_pkg::*;
#(
  parameter int                NUM_ROWS  = 16,
  parameter int                WORD_W    = 8,
  parameter logic [WORD_W-1:0] COMP_MASK = 8'hD5,
  localparam int               IDX_W     = $clog2(NUM_ROWS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqVld,
  input  logic [IDX_W-1:0]  reqIdx,
  output logic              busy,
  output logic              wordVld,
  output logic [WORD_W-1:0] wordOut
);
  tdecStrb_t strb;
  logic      allDone;

  tdec_ctrl #(.NUM_ROWS(NUM_ROWS)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqVld(reqVld), .allDone(allDone),
    .strb(strb), .busy(busy), .wordVld(wordVld)
  );

  tdec_dpath #(.NUM_ROWS(NUM_ROWS), .WORD_W(WORD_W), .COMP_MASK(COMP_MASK)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .reqIdx(reqIdx),
    .allDone(allDone), .wordOut(wordOut)
  );

endmodule

// File: tb/sim_toggle_lut_decoder.sv
`timescale 1ns/1ps
module sim_toggle_lut_decoder;
  localparam int ROWS = 16;
  localparam int W    = 8;
  localparam int IW   = 4;
  localparam logic [W-1:0] MASK = 8'hD5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqVld = 1'b0;
  logic [IW-1:0] reqIdx = '0;
  logic busy, wordVld;
  logic [W-1:0] wordOut;

  int nVec = 0;
  int nFail = 0;
  bit ended = 0;

  always #2 clk = ~clk;

  toggle_lut_decoder #(.NUM_ROWS(ROWS), .WORD_W(W), .COMP_MASK(MASK)) u0 (
    .clk(clk), .rstN(rstN), .reqVld(reqVld), .reqIdx(reqIdx),
    .busy(busy), .wordVld(wordVld), .wordOut(wordOut)
  );

  // Reference table, written from the table definition.
  function automatic logic refBit(int r, int c);
    int gr;
    gr = r ^ (r >> 1);
    case (c)
      7: return r == ROWS - 1;
      6: return 1'b0;
      0: return gr[0];
      2: return gr[1];
      4: return gr[2];
      1: return 1'((r * 5 + 3) >> 0);
      3: return 1'((r * 5 + 3) >> 1);
      default: return 1'((r * 5 + 3) >> 2);
    endcase
  endfunction

  function automatic logic [W-1:0] refWord(int r);
    logic [W-1:0] v;
    for (int c = 0; c < W; c++) v[c] = refBit(r, c);
    return v;
  endfunction

  function automatic int refSteps(int r);
    int best, n;
    best = 0;
    for (int c = 0; c < W; c++) begin
      if (!MASK[c]) continue;
      n = 0;
      for (int q = 1; q <= r; q++) if (refBit(q, c) != refBit(q - 1, c)) n++;
      if (n > best) best = n;
    end
    return best;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    nVec++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
      $finish;
    end
  endtask

  // Issue one request and check the result, the latency and the flags.
  task automatic runOne(int idx, bit full);
    int cnt;
    logic [W-1:0] e;
    e = refWord(idx);
    reqIdx = IW'(idx);
    reqVld = 1'b1;
    @(negedge clk);
    reqVld = 1'b0;
    if (full) check(busy === 1'b1, "R6 busy after accept", busy, 1);
    cnt = 0;
    while (wordVld !== 1'b1 && cnt < 100) begin
      @(negedge clk);
      cnt++;
    end
    check(cnt == refSteps(idx) + 1, "R8 latency", cnt, refSteps(idx) + 1);
    check(wordOut === e, "R9 word", wordOut, e);
    if (full) begin
      check(busy === 1'b0, "R6 busy low with result", busy, 0);
      check((wordOut & ~MASK) === (e & ~MASK), "R3 plain columns", wordOut & ~MASK, e & ~MASK);
      check((wordOut & MASK) === (e & MASK), "R2 compressed columns", wordOut & MASK, e & MASK);
      check(wordOut[6] === 1'b0, "R4 empty list column", wordOut[6], 0);
      check(wordOut[7] === (idx == ROWS - 1), "R5 last-row toggle column", wordOut[7], idx == ROWS - 1);
    end
    @(negedge clk);
    if (full) check(wordVld === 1'b0, "R6 single pulse", wordVld, 0);
  endtask

  initial begin
    #100000;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int seedInit;
    seedInit = $urandom(32'd1357);
    repeat (3) @(negedge clk);
    // R1 reset state
    check(wordVld === 1'b0, "R1 wordVld at reset", wordVld, 0);
    check(busy === 1'b0, "R1 busy at reset", busy, 0);
    check(wordOut === '0, "R1 wordOut at reset", wordOut, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && wordVld === 1'b0, "R1 idle after reset", {busy, wordVld}, 0);

    // R9 full sweep, with corner rows first (R4, R5 on rows 0 and last)
    runOne(0, 1);
    runOne(ROWS - 1, 1);
    runOne(ROWS - 2, 1);
    for (int i = 0; i < ROWS; i++) runOne(i, 1);

    // R7: a request made while busy is dropped
    begin
      logic [W-1:0] e;
      int cnt;
      e = refWord(ROWS - 1);
      reqIdx = IW'(ROWS - 1);
      reqVld = 1'b1;
      @(negedge clk);
      reqIdx = IW'(3);
      reqVld = 1'b1;
      @(negedge clk);
      reqVld = 1'b0;
      cnt = 0;
      while (wordVld !== 1'b1 && cnt < 100) begin
        @(negedge clk);
        cnt++;
      end
      check(wordOut === e, "R7 first row kept", wordOut, e);
      repeat (refSteps(3) + 4) begin
        @(negedge clk);
        check(wordVld === 1'b0, "R7 no result for dropped request", wordVld, 0);
      end
      check(wordOut === e, "R7 word unchanged", wordOut, e);
    end

    // Random rows
    for (int i = 0; i < 60; i++) runOne(int'($urandom_range(ROWS - 1, 0)), (i % 4) == 0);

    finishRun();
  end
endmodule